// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block holds the nine condition flags of an asynchronous serial port. It sits between the CPU bus and the transmit and receive engines. Each engine reports an event as a one-cycle set pulse. The block keeps the flag until software acknowledges it, or until hardware retires it.

Software acknowledges a flag in two steps. First it reads the status word while the flag is set. Then it accesses the data register: a read retires receive-side flags and a write retires transmit-side flags. A flag that sets between those two steps survives the access. A combined status-and-data read retires the receive flags that are set at that moment. It leaves the transmit flags alone.

The line-idle flag follows extra rules. It is held low while the receiver's wake-up mode is on. Once it has cleared, it cannot set again until a received word (a received break counts as one) has been transferred.

Two state machines do the work:
- **Acknowledge machine**
  - States: `ACK_IDLE` and `ACK_ARMED`.
  - Transitions: `ACK_IDLE` goes to `ACK_ARMED` on a status read that sees any flag set. `ACK_ARMED` re-arms on a new status read. It returns to `ACK_IDLE` on a data access or a combined read.
- **Idle re-arm machine**
  - States: `IDL_READY` and `IDL_LOCKED`.
  - Transitions: `IDL_READY` goes to `IDL_LOCKED` when the idle flag falls. `IDL_LOCKED` goes back to `IDL_READY` on a received-word transfer.

Top module: `sps_flag_reg`

## Requirements
- R1: The status word carries the flags at these bit positions: tx_empty at bit 8, tx_done at 7, rx_full at 6, rx_busy at 5, line_idle at 4, overrun at 3, noise at 2, frame at 1 and parity at 0. Bits 15 to 9 read as 0. `flag_lvl` equals bits 8 to 0.
- R2: After reset the status word is 0x0180: tx_empty and tx_done are 1 and every other flag is 0.
- R3: A status read followed by a data read clears the receive flags (rx_full, line_idle, overrun, noise, frame, parity) that the status read saw set.
- R4: A status read followed by a data write clears tx_empty and tx_done if the read saw them set. A data write leaves the receive flags set, and a data read leaves the transmit flags set.
- R5: A flag that sets after the status read is not cleared by the following data access. Clearing it needs a new status read.
- R6: A data access that is not preceded by a status read clears nothing. The first access after a status read consumes the arming, so a second access clears nothing.
- R7: A read strobe on either byte of the status word arms the acknowledge.
- R8: A combined read clears the receive flags that are set in that cycle, and it never clears tx_empty or tx_done.
- R9: When a set pulse and a clear for the same flag fall in the same cycle, the flag ends up set.
- R10: A start-bit pulse sets rx_busy, and an idle-detect pulse clears it. No software access clears rx_busy.
- R11: An idle-detect pulse sets line_idle. While wake-up mode is on, line_idle is forced to 0.
- R12: After line_idle has cleared, idle-detect pulses do not set it again until an rx_xfer pulse arrives.
- R13: A word-transfer pulse that carries error indications sets rx_full and the matching error flags at the same clock edge. An error indication without a transfer pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stat_rd_lo | input | 1 | Read strobe, low byte of status word |
| stat_rd_hi | input | 1 | Read strobe, high byte of status word |
| data_rd | input | 1 | Data register read strobe |
| data_wr | input | 1 | Data register write strobe |
| combo_rd | input | 1 | Combined status-then-data read strobe |
| tx_load | input | 1 | Holding byte moved into the transmit shifter |
| tx_finish | input | 1 | Transmitter has gone idle |
| rx_xfer | input | 1 | Received word moved into the receive data register |
| rx_err_noise | input | 1 | Noise seen in the word being transferred |
| rx_err_frame | input | 1 | Framing error in the word being transferred |
| rx_err_parity | input | 1 | Parity error in the word being transferred |
| rx_overrun | input | 1 | Overrun event pulse |
| rx_start | input | 1 | Possible start bit detected |
| rx_idle_det | input | 1 | Selected idle-line condition detected |
| wake_en | input | 1 | Receiver wake-up mode active |
| status_word | output | 16 | Status word as seen by the CPU |
| flag_lvl | output | 9 | Flag levels |

## Verification
The assertions check the following on every cycle:
- A word-transfer pulse always leaves rx_full set.
- rx_busy only falls on an idle-detect pulse.
- Wake-up mode keeps line_idle low.
- The acknowledged flags never fall without a bus access.
- No clear leaves the acknowledge machine while it is unarmed.
- Transmit clears need a write.
- A locked idle gate never lets line_idle rise.

Only the bench scenarios can show the ordering effects. These are: a flag that sets after the status read surviving the access, the arming being consumed by the first access, the either-byte arming, and the combined read sparing the transmit flags. The scenarios also show line_idle re-arming only after a received word.

// File: rtl/sps_pkg.sv
package sps_pkg;
    localparam int NFLAG = 9;

    localparam int B_PAR = 0;
    localparam int B_FRM = 1;
    localparam int B_NOI = 2;
    localparam int B_OVR = 3;
    localparam int B_IDL = 4;
    localparam int B_BSY = 5;
    localparam int B_RXF = 6;
    localparam int B_TXD = 7;
    localparam int B_TXE = 8;

    typedef logic [NFLAG-1:0] flag_vec_t;

    localparam flag_vec_t TX_ACK_MASK = flag_vec_t'((1 << B_TXE) | (1 << B_TXD));
    localparam flag_vec_t RX_ACK_MASK = flag_vec_t'((1 << B_RXF) | (1 << B_IDL) | (1 << B_OVR)
                                                    | (1 << B_NOI) | (1 << B_FRM) | (1 << B_PAR));
    localparam flag_vec_t RESET_FLAGS = TX_ACK_MASK;
    localparam flag_vec_t HOLD_MASK   = TX_ACK_MASK | RX_ACK_MASK & ~flag_vec_t'(1 << B_IDL);

    typedef enum logic {ACK_IDLE, ACK_ARMED}   ack_state_e;
    typedef enum logic {IDL_READY, IDL_LOCKED} idle_state_e;
endpackage

// File: rtl/sps_ack_ctrl.sv
module sps_ack_ctrl
    import sps_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      stat_rd,
    input  logic      data_rd,
    input  logic      data_wr,
    input  logic      combo_rd,
    input  flag_vec_t flags_i,
    output flag_vec_t clr_o
);
    ack_state_e st_q, st_d;
    flag_vec_t  armed_q, armed_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ACK_IDLE;
            armed_q <= '0;
        end else begin
            st_q    <= st_d;
            armed_q <= armed_d;
        end
    end

    always_comb begin
        st_d    = st_q;
        armed_d = armed_q;
        unique case (st_q)
            ACK_IDLE: begin
                if (stat_rd && !combo_rd && (|flags_i)) begin
                    st_d    = ACK_ARMED;
                    armed_d = flags_i;
                end
            end
            ACK_ARMED: begin
                if (combo_rd) begin
                    st_d    = ACK_IDLE;
                    armed_d = '0;
                end else if (stat_rd) begin
                    st_d    = (|flags_i) ? ACK_ARMED : ACK_IDLE;
                    armed_d = flags_i;
                end else if (data_rd || data_wr) begin
                    st_d    = ACK_IDLE;
                    armed_d = '0;
                end
            end
        endcase
    end

    always_comb begin
        clr_o = '0;
        if (combo_rd) begin
            clr_o = flags_i & RX_ACK_MASK;
        end else if (st_q == ACK_ARMED) begin
            if (data_rd) clr_o = clr_o | (armed_q & flags_i & RX_ACK_MASK);
            if (data_wr) clr_o = clr_o | (armed_q & flags_i & TX_ACK_MASK);
        end
    end

    // R6
    no_blind_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ACK_IDLE && !combo_rd) |-> (clr_o == '0));

    // R4
    tx_clear_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_wr) |-> ((clr_o & TX_ACK_MASK) == '0));
endmodule

// File: rtl/sps_idle_gate.sv
module sps_idle_gate
    import sps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic idle_q_i,
    input  logic idle_d_i,
    input  logic rx_xfer,
    output logic allow_o
);
    idle_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= IDL_READY;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IDL_READY:  if (idle_q_i && !idle_d_i && !rx_xfer) st_d = IDL_LOCKED;
            IDL_LOCKED: if (rx_xfer) st_d = IDL_READY;
        endcase
    end

    always_comb allow_o = (st_q == IDL_READY);

    // R12
    locked_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == IDL_LOCKED) |=> !$rose(idle_q_i));
endmodule

// File: rtl/sps_flag_reg.sv
module sps_flag_reg
    import sps_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_rd_lo,
    input  logic              stat_rd_hi,
    input  logic              data_rd,
    input  logic              data_wr,
    input  logic              combo_rd,
    input  logic              tx_load,
    input  logic              tx_finish,
    input  logic              rx_xfer,
    input  logic              rx_err_noise,
    input  logic              rx_err_frame,
    input  logic              rx_err_parity,
    input  logic              rx_overrun,
    input  logic              rx_start,
    input  logic              rx_idle_det,
    input  logic              wake_en,
    output logic [WORD_W-1:0] status_word,
    output logic [NFLAG-1:0]  flag_lvl
);
    localparam int PAD_W = WORD_W - NFLAG;

    flag_vec_t flag_q, flag_d, set_v, clr_v, ack_clr;
    logic      idle_allow;

    sps_ack_ctrl u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_rd  (stat_rd_lo | stat_rd_hi),
        .data_rd  (data_rd),
        .data_wr  (data_wr),
        .combo_rd (combo_rd),
        .flags_i  (flag_q),
        .clr_o    (ack_clr)
    );

    sps_idle_gate u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .idle_q_i (flag_q[B_IDL]),
        .idle_d_i (flag_d[B_IDL]),
        .rx_xfer  (rx_xfer),
        .allow_o  (idle_allow)
    );

    always_comb begin
        set_v        = '0;
        set_v[B_TXE] = tx_load;
        set_v[B_TXD] = tx_finish;
        set_v[B_RXF] = rx_xfer;
        set_v[B_NOI] = rx_xfer & rx_err_noise;
        set_v[B_FRM] = rx_xfer & rx_err_frame;
        set_v[B_PAR] = rx_xfer & rx_err_parity;
        set_v[B_OVR] = rx_overrun;
        set_v[B_BSY] = rx_start;
        set_v[B_IDL] = rx_idle_det & idle_allow & !wake_en;

        clr_v        = ack_clr;
        clr_v[B_BSY] = rx_idle_det;

        flag_d = (flag_q & ~clr_v) | set_v;
        if (wake_en) flag_d[B_IDL] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= RESET_FLAGS;
        else        flag_q <= flag_d;
    end

    always_comb begin
        status_word = {{PAD_W{1'b0}}, flag_q};
        flag_lvl    = flag_q;
    end

    // R9
    rx_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_xfer |=> flag_q[B_RXF]);

    // R10
    busy_sw_proof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[B_BSY] && !rx_idle_det) |=> flag_q[B_BSY]);

    // R11
    wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_en |=> !flag_q[B_IDL]);

    // R5
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_rd && !data_wr && !combo_rd) |=> (($past(flag_q) & ~flag_q & HOLD_MASK) == '0));
endmodule

// File: tb/sps_flag_reg_tb.sv
`timescale 1ns/1ps
module sps_flag_reg_tb_top;
    localparam logic [14:0] SLO = 15'h0001;
    localparam logic [14:0] SHI = 15'h0002;
    localparam logic [14:0] DRD = 15'h0004;
    localparam logic [14:0] DWR = 15'h0008;
    localparam logic [14:0] CMB = 15'h0010;
    localparam logic [14:0] TXL = 15'h0020;
    localparam logic [14:0] TXF = 15'h0040;
    localparam logic [14:0] RXX = 15'h0080;
    localparam logic [14:0] NOI = 15'h0100;
    localparam logic [14:0] FRM = 15'h0200;
    localparam logic [14:0] PAR = 15'h0400;
    localparam logic [14:0] OVR = 15'h0800;
    localparam logic [14:0] STR = 15'h1000;
    localparam logic [14:0] IDP = 15'h2000;
    localparam logic [14:0] WAK = 15'h4000;

    typedef struct packed {
        logic [3:0]  req;
        logic [14:0] st;
        logic [15:0] ex;
    } vec_t;

    localparam int NVEC = 27;
    localparam vec_t VEC [0:NVEC-1] = '{
        '{4'd7,  SLO,             16'h0180},  // R7 low byte arms
        '{4'd4,  DWR,             16'h0000},  // R4 write clears tx flags
        '{4'd4,  TXL,             16'h0100},
        '{4'd4,  TXF,             16'h0180},
        '{4'd13, RXX | NOI | FRM, 16'h01C6},  // R13 same-edge error set
        '{4'd6,  DRD,             16'h01C6},  // R6 no prior read
        '{4'd7,  SHI,             16'h01C6},  // R7 high byte arms
        '{4'd3,  DRD,             16'h0180},  // R3 read clears rx flags
        '{4'd6,  DRD,             16'h0180},  // R6 arming consumed
        '{4'd10, STR,             16'h01A0},  // R10 start sets busy
        '{4'd10, IDP,             16'h0190},  // R10 / R11 idle pulse
        '{4'd3,  SLO,             16'h0190},
        '{4'd5,  OVR,             16'h0198},
        '{4'd5,  DRD,             16'h0188},  // R5 late overrun survives
        '{4'd12, IDP,             16'h0188},  // R12 locked
        '{4'd12, RXX,             16'h01C8},
        '{4'd12, IDP,             16'h01D8},  // R12 re-armed
        '{4'd11, WAK,             16'h01C8},  // R11 wake forces 0
        '{4'd10, STR,             16'h01E8},
        '{4'd3,  SLO,             16'h01E8},
        '{4'd4,  DWR,             16'h0068},  // R4 write spares rx, busy
        '{4'd3,  SLO,             16'h0068},
        '{4'd9,  DRD | RXX | PAR, 16'h0061},  // R9 set wins
        '{4'd4,  TXL,             16'h0161},
        '{4'd8,  CMB,             16'h0120},  // R8 combo spares tx
        '{4'd10, IDP,             16'h0110},
        '{4'd8,  CMB,             16'h0100}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] stim = '0;
    logic [15:0] status_word;
    logic [8:0]  flag_lvl;
    int          n_chk = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    sps_flag_reg dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .stat_rd_lo    (stim[0]),
        .stat_rd_hi    (stim[1]),
        .data_rd       (stim[2]),
        .data_wr       (stim[3]),
        .combo_rd      (stim[4]),
        .tx_load       (stim[5]),
        .tx_finish     (stim[6]),
        .rx_xfer       (stim[7]),
        .rx_err_noise  (stim[8]),
        .rx_err_frame  (stim[9]),
        .rx_err_parity (stim[10]),
        .rx_overrun    (stim[11]),
        .rx_start      (stim[12]),
        .rx_idle_det   (stim[13]),
        .wake_en       (stim[14]),
        .status_word   (status_word),
        .flag_lvl      (flag_lvl)
    );

    task automatic check_word(input int req, input logic [15:0] exp);
        n_chk++;
        if (status_word !== exp || flag_lvl !== exp[8:0]) begin
            n_fail++;
            $display("FAIL R%0d: status_word=%h flag_lvl=%h expected %h", req, status_word, flag_lvl, exp);
        end
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run hung, actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_word(2, 16'h0180);          // R2 held in reset
        rst_n = 1'b1;
        @(negedge clk);
        check_word(1, 16'h0180);          // R1 upper bits zero, flag_lvl mirrors

        for (int i = 0; i < NVEC; i++) begin
            stim = VEC[i].st;
            @(negedge clk);
            check_word(int'(VEC[i].req), VEC[i].ex);
        end
        stim = '0;

        // R13 error indication without transfer has no effect
        stim = NOI | FRM | PAR;
        @(negedge clk);
        check_word(13, 16'h0100);
        stim = '0;

        // R10 busy survives status read then data read
        stim = STR;
        @(negedge clk);
        stim = SLO;
        @(negedge clk);
        stim = DRD;
        @(negedge clk);
        check_word(10, 16'h0120);
        stim = '0;

        // R2 reset mid-run restores defaults
        #1 rst_n = 1'b0;
        #2;
        check_word(2, 16'h0180);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_word(2, 16'h0180);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule